// File: doc/BRIEF.md
# Register Segment Allocation Table

This block hands out contiguous slices of one physical register file (one register class, integer or floating point) to hardware threads on demand. A thread owns no registers until its first instruction that touches the class reaches rename. That instruction's logical register index sets the slice size: index plus one. The slice is taken at the tail of a circular slot table. The start of the slice is the running allocation pointer, and the physical register space wraps modulo the file size. Later instructions of the same thread hit the table, and each logical number is translated by adding it to the slice start.

Threads release their slice through a free port keyed by thread id. The freed slot can sit anywhere in the table and becomes a hole. Every cycle the table releases one hole at the head and one at the tail without moving any live entry. A tail release also pulls the allocation pointer back. When an allocation cannot be served, rename receives a kill for that thread and the table records the requested size for it. A thread that has been killed more than a set number of times in a row takes part in a gap search. The search walks from the head for the first hole at least as large as the recorded size and hands that hole to the thread as a special segment. Each successful free raises a one-cycle pulse that a thread table can use as its retry flag.

Top module: `seg_alloc_table`

## Requirements
- R1: After reset the table is empty, grant_o, kill_o, special_o and free_pulse_o are 0, and with req_valid_i low none of grant_o, kill_o or special_o is asserted.
- R2: A request from a thread with no segment is granted in the same cycle when a slot is free and at least lreg+1 unused registers remain. The new segment starts at the allocation pointer, which is 0 after reset and advances by the size. grant_preg_o equals that start plus the logical index.
- R3: A request from a thread that owns a segment is granted with grant_preg_o = (start + logical index) mod PREG, so a segment may span the end of the file.
- R4: When a new segment fits neither in the slots nor in the remaining registers, and no special grant applies, kill_o is asserted and grant_o stays low. A valid request always yields exactly one of grant_o and kill_o.
- R5: Each kill increments the thread's consecutive-failure count and records its requested size. Any grant to that thread clears the count.
- R6: When the failure count of the requesting thread exceeds RETRY_LIMIT (default 10), the table scans from the head through the occupied range for the first freed slot whose size is at least the recorded size. On a find it grants with special_o=1 and grant_preg_o = hole start + logical index, and the hole becomes the thread's segment.
- R7: A free for a thread owning a segment removes that segment wherever it sits. The thread's next request is treated as a new allocation.
- R8: free_pulse_o is 1 for exactly the cycle after a free that matched a segment, and stays 0 for a free of a thread without one.
- R9: Freed slots at the head and at the tail are retired one per end per cycle without moving live entries. Retiring a tail hole returns its registers to the allocation pointer, so the next new segment reuses that start.
- R10: An allocation and a free in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Rename lookup/allocate request |
| req_tid_i | input | TID_W | Requesting thread |
| req_lreg_i | input | LREG_W | Logical register index |
| free_valid_i | input | 1 | Release request |
| free_tid_i | input | TID_W | Thread whose segment is released |
| grant_o | output | 1 | Request served, translation valid |
| grant_preg_o | output | PREG_W | Physical register number |
| kill_o | output | 1 | Allocation failed: discard thread's front-end work |
| special_o | output | 1 | Grant came from the gap search |
| free_pulse_o | output | 1 | One-cycle pulse after a successful free |

## Verification
Allocation at the tail and release of a segment can fall in the same cycle, and so can a new allocation and the retirement of a head hole. The bench provokes both with directed sequences, such as a new request in the cycle that frees an older thread. It also applies long random runs in which requests and frees are issued independently on every cycle. A reference model updated once per clock predicts the grant, kill, special flag, translated number and pulse. It applies every change of a cycle against the state before that clock, so a lost free, a double-counted size or a misplaced allocation pointer shows up as a wrong physical number or a wrong kill later on.

// File: rtl/seg_pkg.sv
`timescale 1ns/1ps
package seg_pkg;
  typedef enum logic [2:0] {
    RES_IDLE,
    RES_HIT,
    RES_NEW,
    RES_SPECIAL,
    RES_KILL
  } seg_res_e;
endpackage

// File: rtl/seg_cam.sv
`timescale 1ns/1ps
module seg_cam #(
  parameter int NUM_SLOTS = 16,
  parameter int TID_W     = 5,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0]            valid_i,
  input  logic [NUM_SLOTS-1:0][TID_W-1:0] tid_i,
  input  logic [TID_W-1:0]                key_i,
  output logic                            hit_o,
  output logic [SLOT_W-1:0]               idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (valid_i[i] && tid_i[i] == key_i) begin
        hit_o = 1'b1;
        idx_o = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/seg_gap_find.sv
`timescale 1ns/1ps
module seg_gap_find #(
  parameter int NUM_SLOTS = 16,
  parameter int SIZE_W    = 6,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int CNT_W    = SLOT_W + 1
) (
  input  logic [NUM_SLOTS-1:0]             valid_i,
  input  logic [NUM_SLOTS-1:0][SIZE_W-1:0] size_i,
  input  logic [SLOT_W-1:0]                head_i,
  input  logic [CNT_W-1:0]                 cnt_i,
  input  logic [SIZE_W-1:0]                need_i,
  output logic                             found_o,
  output logic [SLOT_W-1:0]                idx_o
);
  // descending walk: the last write wins, so the hole nearest the head is kept
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (CNT_W'(k) < cnt_i &&
          !valid_i[head_i + SLOT_W'(k)] &&
          size_i[head_i + SLOT_W'(k)] >= need_i) begin
        found_o = 1'b1;
        idx_o   = head_i + SLOT_W'(k);
      end
    end
  end
endmodule

// File: rtl/seg_retry.sv
`timescale 1ns/1ps
module seg_retry #(
  parameter int NUM_THREADS = 32,
  parameter int SIZE_W      = 6,
  parameter int RETRY_LIMIT = 10,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int RC_W       = $clog2(RETRY_LIMIT + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TID_W-1:0]  tid_i,
  input  logic              fail_i,
  input  logic              clear_i,
  input  logic [SIZE_W-1:0] need_i,
  output logic              over_o,
  output logic [SIZE_W-1:0] rec_size_o
);
  localparam logic [RC_W-1:0] SAT = RC_W'(RETRY_LIMIT + 1);

  logic [NUM_THREADS-1:0][RC_W-1:0]   cnt_q;
  logic [NUM_THREADS-1:0][SIZE_W-1:0] rec_q;

  assign over_o     = cnt_q[tid_i] > RC_W'(RETRY_LIMIT);
  assign rec_size_o = rec_q[tid_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rec_q <= '0;
    end else if (fail_i) begin
      rec_q[tid_i] <= need_i;
      if (cnt_q[tid_i] != SAT) cnt_q[tid_i] <= cnt_q[tid_i] + 1'b1;
    end else if (clear_i) begin
      cnt_q[tid_i] <= '0;
    end
  end

  AST_FAIL_CLEAR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fail_i && clear_i)); // R5
endmodule

// File: rtl/seg_alloc_table.sv
`timescale 1ns/1ps
module seg_alloc_table
  import seg_pkg::*;
#(
  parameter int NUM_SLOTS   = 16,
  parameter int PREG        = 128,
  parameter int NUM_THREADS = 32,
  parameter int NUM_LREG    = 32,
  parameter int RETRY_LIMIT = 10,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int LREG_W     = $clog2(NUM_LREG),
  localparam int PREG_W     = $clog2(PREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [TID_W-1:0]  req_tid_i,
  input  logic [LREG_W-1:0] req_lreg_i,
  input  logic              free_valid_i,
  input  logic [TID_W-1:0]  free_tid_i,
  output logic              grant_o,
  output logic [PREG_W-1:0] grant_preg_o,
  output logic              kill_o,
  output logic              special_o,
  output logic              free_pulse_o
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int CNT_W  = SLOT_W + 1;
  localparam int SIZE_W = LREG_W + 1;
  localparam int SPAN_W = PREG_W + 1;
  localparam logic [SLOT_W-1:0] S_ONE = SLOT_W'(1);

  // slot table
  logic [NUM_SLOTS-1:0]             slot_valid_q;
  logic [NUM_SLOTS-1:0][PREG_W-1:0] slot_start_q;
  logic [NUM_SLOTS-1:0][SIZE_W-1:0] slot_size_q;
  logic [NUM_SLOTS-1:0][TID_W-1:0]  slot_tid_q;
  logic [SLOT_W-1:0]                head_q, tail_q;
  logic [CNT_W-1:0]                 cnt_q;
  logic [SPAN_W-1:0]                span_q;
  logic [PREG_W-1:0]                aptr_q;
  logic                             pulse_q;

  logic              look_hit, free_hit, gap_found, retry_over;
  logic [SLOT_W-1:0] look_idx, free_idx, gap_idx, tail_prev;
  logic [SIZE_W-1:0] need, rec_size;
  logic              tail_ok, head_cmp, tail_cmp;
  logic [PREG_W-1:0] base;
  seg_res_e          res;

  assign need      = SIZE_W'(req_lreg_i) + SIZE_W'(1);
  assign tail_prev = tail_q - S_ONE;
  assign tail_ok   = (cnt_q < CNT_W'(NUM_SLOTS)) &&
                     (SPAN_W'(need) <= SPAN_W'(PREG) - span_q);

  seg_cam #(.NUM_SLOTS(NUM_SLOTS), .TID_W(TID_W)) u_look (
    .valid_i(slot_valid_q), .tid_i(slot_tid_q), .key_i(req_tid_i),
    .hit_o(look_hit), .idx_o(look_idx)
  );

  seg_cam #(.NUM_SLOTS(NUM_SLOTS), .TID_W(TID_W)) u_free (
    .valid_i(slot_valid_q), .tid_i(slot_tid_q), .key_i(free_tid_i),
    .hit_o(free_hit), .idx_o(free_idx)
  );

  seg_gap_find #(.NUM_SLOTS(NUM_SLOTS), .SIZE_W(SIZE_W)) u_gap (
    .valid_i(slot_valid_q), .size_i(slot_size_q), .head_i(head_q),
    .cnt_i(cnt_q), .need_i(rec_size),
    .found_o(gap_found), .idx_o(gap_idx)
  );

  seg_retry #(.NUM_THREADS(NUM_THREADS), .SIZE_W(SIZE_W),
              .RETRY_LIMIT(RETRY_LIMIT)) u_retry (
    .clk_i, .rst_ni,
    .tid_i(req_tid_i),
    .fail_i(res == RES_KILL),
    .clear_i(grant_o),
    .need_i(need),
    .over_o(retry_over),
    .rec_size_o(rec_size)
  );

  always_comb begin
    res = RES_IDLE;
    if (req_valid_i) begin
      if (look_hit)                     res = RES_HIT;
      else if (tail_ok)                 res = RES_NEW;
      else if (retry_over && gap_found) res = RES_SPECIAL;
      else                              res = RES_KILL;
    end
  end

  always_comb begin
    unique case (res)
      RES_HIT:     base = slot_start_q[look_idx];
      RES_SPECIAL: base = slot_start_q[gap_idx];
      default:     base = aptr_q;
    endcase
  end

  assign grant_o      = res == RES_HIT || res == RES_NEW || res == RES_SPECIAL;
  assign kill_o       = res == RES_KILL;
  assign special_o    = res == RES_SPECIAL;
  assign grant_preg_o = base + PREG_W'(req_lreg_i);
  assign free_pulse_o = pulse_q;

  // partial compression: retire holes at either end, never move live slots
  assign head_cmp = (cnt_q != '0) && !slot_valid_q[head_q] &&
                    !(res == RES_SPECIAL && gap_idx == head_q);
  assign tail_cmp = (res != RES_NEW) && (cnt_q >= CNT_W'(2)) &&
                    !slot_valid_q[tail_prev] &&
                    !(res == RES_SPECIAL && gap_idx == tail_prev);

  logic [SPAN_W-1:0] add_sz, head_sz, tail_sz;
  assign add_sz  = (res == RES_NEW) ? SPAN_W'(need) : '0;
  assign head_sz = head_cmp ? SPAN_W'(slot_size_q[head_q]) : '0;
  assign tail_sz = tail_cmp ? SPAN_W'(slot_size_q[tail_prev]) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_valid_q <= '0;
      slot_start_q <= '0;
      slot_size_q  <= '0;
      slot_tid_q   <= '0;
      head_q       <= '0;
      tail_q       <= '0;
      cnt_q        <= '0;
      span_q       <= '0;
      aptr_q       <= '0;
      pulse_q      <= 1'b0;
    end else begin
      pulse_q <= free_valid_i && free_hit;
      if (free_valid_i && free_hit) slot_valid_q[free_idx] <= 1'b0;
      if (res == RES_NEW) begin
        slot_valid_q[tail_q] <= 1'b1;
        slot_start_q[tail_q] <= aptr_q;
        slot_size_q[tail_q]  <= need;
        slot_tid_q[tail_q]   <= req_tid_i;
      end
      if (res == RES_SPECIAL) begin
        slot_valid_q[gap_idx] <= 1'b1;
        slot_tid_q[gap_idx]   <= req_tid_i;
      end
      head_q <= head_q + SLOT_W'(head_cmp);
      tail_q <= tail_q + SLOT_W'(res == RES_NEW) - SLOT_W'(tail_cmp);
      cnt_q  <= cnt_q + CNT_W'(res == RES_NEW) - CNT_W'(head_cmp)
                      - CNT_W'(tail_cmp);
      span_q <= span_q + add_sz - head_sz - tail_sz;
      aptr_q <= aptr_q + PREG_W'(add_sz) - PREG_W'(tail_sz);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !grant_o && !kill_o && !special_o); // R1
  AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_SLOTS)); // R2
  AST_SPAN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    span_q <= SPAN_W'(PREG)); // R2
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (grant_o ^ kill_o)); // R4
  AST_SPECIAL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    special_o |-> retry_over && !slot_valid_q[gap_idx]); // R6
  AST_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_pulse_o |-> $past(free_valid_i)); // R8
endmodule

// File: tb/tb_seg_alloc_table.sv
`timescale 1ns/1ps
module tb_seg_alloc_table;
  localparam int N    = 16;
  localparam int PR   = 128;
  localparam int NT   = 32;
  localparam int NL   = 32;
  localparam int LIM  = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [4:0] req_tid_i = '0;
  logic [4:0] req_lreg_i = '0;
  logic       free_valid_i = 1'b0;
  logic [4:0] free_tid_i = '0;
  logic       grant_o, kill_o, special_o, free_pulse_o;
  logic [6:0] grant_preg_o;

  always #2.5 clk_i = ~clk_i;

  seg_alloc_table #(.NUM_SLOTS(N), .PREG(PR), .NUM_THREADS(NT),
                    .NUM_LREG(NL), .RETRY_LIMIT(LIM)) dut (.*);

  int n_vec = 0, n_err = 0;
  bit done = 0;

  // reference model
  int m_valid[N], m_start[N], m_size[N], m_tid[N];
  int m_head, m_tail, m_cnt, m_span, m_aptr, m_pulse;
  int m_fail[NT], m_rec[NT];
  int i_rv, i_rt, i_rl, i_fv, i_ft;
  int e_kind, e_hidx, e_gidx, e_need, e_preg;

  function automatic void model_reset();
    for (int s = 0; s < N; s++) begin
      m_valid[s] = 0; m_start[s] = 0; m_size[s] = 0; m_tid[s] = 0;
    end
    for (int t = 0; t < NT; t++) begin m_fail[t] = 0; m_rec[t] = 0; end
    m_head = 0; m_tail = 0; m_cnt = 0; m_span = 0; m_aptr = 0; m_pulse = 0;
  endfunction

  // kinds: 0 idle, 1 hit, 2 new, 3 special, 4 kill
  function automatic void model_eval();
    int base;
    bit tok;
    e_need = i_rl + 1;
    e_hidx = -1;
    for (int s = 0; s < N; s++)
      if (m_valid[s] != 0 && m_tid[s] == i_rt) e_hidx = s;
    e_gidx = -1;
    for (int k = 0; k < m_cnt; k++) begin
      int s = (m_head + k) % N;
      if (e_gidx < 0 && m_valid[s] == 0 && m_size[s] >= m_rec[i_rt]) e_gidx = s;
    end
    tok = (m_cnt < N) && (e_need <= PR - m_span);
    if (i_rv == 0) e_kind = 0;
    else if (e_hidx >= 0) e_kind = 1;
    else if (tok) e_kind = 2;
    else if (m_fail[i_rt] > LIM && e_gidx >= 0) e_kind = 3;
    else e_kind = 4;
    base = (e_kind == 1) ? m_start[e_hidx] : (e_kind == 3) ? m_start[e_gidx] : m_aptr;
    e_preg = (base + i_rl) % PR;
  endfunction

  function automatic void model_commit();
    int tp, hsz, tsz, fidx;
    bit hc, tc;
    tp  = (m_tail + N - 1) % N;
    hc  = m_cnt > 0 && m_valid[m_head] == 0 && !(e_kind == 3 && e_gidx == m_head);
    tc  = e_kind != 2 && m_cnt >= 2 && m_valid[tp] == 0 && !(e_kind == 3 && e_gidx == tp);
    hsz = hc ? m_size[m_head] : 0;
    tsz = tc ? m_size[tp] : 0;
    fidx = -1;
    for (int s = 0; s < N; s++)
      if (m_valid[s] != 0 && m_tid[s] == i_ft) fidx = s;
    m_pulse = (i_fv != 0 && fidx >= 0) ? 1 : 0;
    if (m_pulse != 0) m_valid[fidx] = 0;
    if (e_kind == 2) begin
      m_valid[m_tail] = 1; m_start[m_tail] = m_aptr;
      m_size[m_tail] = e_need; m_tid[m_tail] = i_rt;
    end
    if (e_kind == 3) begin m_valid[e_gidx] = 1; m_tid[e_gidx] = i_rt; end
    if (e_kind == 4) begin
      m_rec[i_rt] = e_need;
      if (m_fail[i_rt] < LIM + 1) m_fail[i_rt]++;
    end else if (e_kind != 0) m_fail[i_rt] = 0;
    m_span = m_span + (e_kind == 2 ? e_need : 0) - hsz - tsz;
    m_aptr = (m_aptr + (e_kind == 2 ? e_need : 0) - tsz + PR) % PR;
    m_cnt  = m_cnt + (e_kind == 2 ? 1 : 0) - (hc ? 1 : 0) - (tc ? 1 : 0);
    m_head = (m_head + (hc ? 1 : 0)) % N;
    m_tail = (m_tail + (e_kind == 2 ? 1 : 0) - (tc ? 1 : 0) + N) % N;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int rv, int rt, int rl, int fv, int ft, string tag);
    string t;
    @(negedge clk_i);
    req_valid_i = rv[0]; req_tid_i = rt[4:0]; req_lreg_i = rl[4:0];
    free_valid_i = fv[0]; free_tid_i = ft[4:0];
    i_rv = rv; i_rt = rt; i_rl = rl; i_fv = fv; i_ft = ft;
    #1;
    model_eval();
    if (tag != "") t = tag;
    else case (e_kind)
      1: t = "R3"; 2: t = "R2"; 3: t = "R6"; 4: t = "R4"; default: t = "R1";
    endcase
    chk({t, " grant"}, int'(grant_o), (e_kind >= 1 && e_kind <= 3) ? 1 : 0);
    chk({t, " kill"}, int'(kill_o), e_kind == 4 ? 1 : 0);
    chk({t, " special"}, int'(special_o), e_kind == 3 ? 1 : 0);
    if (e_kind >= 1 && e_kind <= 3) chk({t, " preg"}, int'(grant_preg_o), e_preg);
    chk("R8 pulse", int'(free_pulse_o), m_pulse);
    @(posedge clk_i);
    model_commit();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_valid_i = 0; free_valid_i = 0;
    repeat (2) @(posedge clk_i);
    model_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 grant after reset", int'(grant_o), 0);
    chk("R1 kill after reset", int'(kill_o), 0);
    chk("R1 pulse after reset", int'(free_pulse_o), 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a1c));
    do_reset();
    step(0, 0, 0, 0, 0, "R1");
    step(1, 3, 5, 0, 0, "R1");                 // first segment starts at 0
    chk("R1 first preg", int'(grant_preg_o), 5);

    // R6 / R5: fill the file, free a middle slot, starve a thread
    do_reset();
    for (int t = 0; t < 4; t++) step(1, t, 31, 0, 0, "R2");
    step(0, 0, 0, 1, 1, "R7");
    for (int k = 0; k < 11; k++) step(1, 4, 15, 0, 0, "R5");
    step(1, 4, 15, 0, 0, "R6");
    chk("R6 special preg", int'(grant_preg_o), 47);
    chk("R6 special flag", int'(special_o), 1);
    step(1, 4, 3, 0, 0, "R5");                 // now a hit
    chk("R5 hit after special", int'(grant_preg_o), 35);

    // R3: segment spanning the end of the file
    do_reset();
    for (int t = 0; t < 3; t++) step(1, t, 31, 0, 0, "R2");
    step(1, 3, 15, 0, 0, "R2");
    step(0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, "R9");                 // head hole retired
    step(1, 4, 31, 0, 0, "R3");
    chk("R3 wrap preg", int'(grant_preg_o), 15);
    step(1, 4, 20, 0, 0, "R3");
    chk("R3 wrap hit", int'(grant_preg_o), 4);

    // R9: tail hole gives its registers back
    do_reset();
    step(1, 0, 7, 0, 0, "R2");
    step(1, 1, 7, 0, 0, "R2");
    step(0, 0, 0, 1, 1, "R9");
    step(0, 0, 0, 0, 0, "R9");
    step(1, 2, 3, 0, 0, "R9");
    chk("R9 reuse start", int'(grant_preg_o), 11);

    // R10 / R7: new allocation and free in one cycle
    step(1, 5, 1, 1, 0, "R10");
    chk("R10 alloc with free", int'(grant_preg_o), 13);
    step(1, 0, 2, 0, 0, "R7");                 // thread 0 reallocates
    chk("R7 realloc preg", int'(grant_preg_o), 16);
    step(0, 0, 0, 1, 9, "R8");                 // no segment for thread 9
    step(0, 0, 0, 0, 0, "R8");

    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int c = 0; c < 1500; c++) begin
        int rv, rt, fv;
        rv = ($urandom % 10) < 7 ? 1 : 0;
        rt = ($urandom % 4 == 0) ? ($urandom % NT) : ($urandom % 8);
        fv = ($urandom % 8 == 0) ? 1 : 0;
        step(rv, rt, $urandom % NL, fv, $urandom % NT, "");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule